// File: doc/BRIEF.md
# Minimum Pulse-Width Qualifier

This block lets through only the tail of an input pulse that outlasts a programmed minimum width. The asynchronous level on `pulse_in` is first brought into the clock domain. When the synchronised level rises and the internal interval timer is idle, the timer is loaded with the value on `min_width` at that moment. The output stays low while the timer runs. Once the timer has expired, the output follows the synchronised input for as long as the same pulse stays high.

As a result, a pulse no longer than the programmed width gives no output at all. A longer pulse comes out shortened by exactly the programmed number of cycles. The timer cannot be retriggered, so a new pulse that starts while it is still counting is never qualified. The block suits glitch or short-burst rejection in front of logic that must only react to sustained levels.

Top module: `pulse_width_qualifier`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pulse_out` is low and stays low while `pulse_in` is held low.
- R2: A rising edge of the synchronised input that finds the timer idle loads the timer with the value of `min_width` at that cycle. A later change of `min_width` does not alter a running interval.
- R3: `pulse_out` is low in every cycle in which the interval timer is still counting.
- R4: An input pulse that is sampled high for L consecutive clock edges, with L greater than the programmed width N, gives exactly one output pulse of L−N cycles. That output is first high after the (N+2)-th clock edge, counted from and including the first edge that samples `pulse_in` high.
- R5: An input pulse with L less than or equal to N produces no output at all.
- R6: A rising edge that arrives while the timer is counting is ignored. The pulse it begins never reaches the output, even if it lasts beyond the expiry of the timer.
- R7: After a pulse that was too short, the timer still runs to completion. The first rising edge after expiry is then qualified normally as in R4.
- R8: With N = 0 the output reproduces each input pulse at full length L, delayed by two clock edges.
- R9: `pulse_out` falls one clock edge after `pulse_in` is first sampled low, which is the same edge on which the synchronised input drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Asynchronous input level to be qualified |
| min_width | input | CNT_W | Minimum pulse width N in clock cycles, sampled at each accepted rising edge |
| pulse_out | output | 1 | Qualified output: the input pulse with its first N cycles removed |

## Verification
The first clock edge that samples `pulse_in` high is edge 0. The qualified output is due after edge N+1. It drops after the edge that follows the first low sample of `pulse_in`. The bench drives `pulse_in` and `min_width` on falling edges and samples `pulse_out` on the next falling edge. Each sample then reflects exactly one rising edge, and the recorded index of the first high sample and the count of high samples are compared with N+2 and L−N. For suppressed pulses, the bench keeps sampling for several cycles beyond the timer's expiry and the input's fall, so that a late or leaked output would still be seen.

// File: rtl/pwq_pkg.sv
// Package: pwq_pkg
// Shared defaults for the pulse-width qualifier. Assumes nothing beyond
// being compiled ahead of every module that imports it.
package pwq_pkg;
    // Default width of the programmed interval counter.
    localparam int unsigned PWQ_CNT_W_DEF  = 8;
    // Default number of synchronizer flops (at least two).
    localparam int unsigned PWQ_SYNC_DEF   = 2;
    // Lowest synchronizer depth the design supports.
    localparam int unsigned PWQ_SYNC_MIN   = 2;
endpackage

// File: rtl/pwq_sync.sv
// Module: pwq_sync
// Multi-flop synchronizer for a single asynchronous level. Exposes the
// final synchronised level and the stage just before it, so that a
// consumer can register a value in step with the final stage.
// Assumes STAGES >= 2 and a synchronous active-low reset to zero.
module pwq_sync
    import pwq_pkg::*;
#(
    parameter int unsigned STAGES = PWQ_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lead_out,
    output logic sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Purpose: shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], async_in};
    end

    // Purpose: tap the final and penultimate stages.
    always_comb begin
        sync_out = chain_q[LAST];
        lead_out = chain_q[LAST-1];
    end

    // Purpose: check the configured depth at elaboration.
    generate
        if (STAGES < PWQ_SYNC_MIN) begin : g_bad_depth
            initial $display("pwq_sync: STAGES below minimum");
        end
    endgenerate
endmodule

// File: rtl/pwq_timer.sv
// Module: pwq_timer
// Non-retriggerable down-counter. A start request while idle loads the
// programmed interval; start requests while counting are dropped. Also
// reports whether the counter will be at zero after the current edge.
// Assumes load_val is stable only in the start cycle.
module pwq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             accepted,
    output logic             done_next
);
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] rem_d;

    // Purpose: decide acceptance and the next remaining count.
    always_comb begin
        busy     = (rem_q != '0);
        accepted = start_req && !busy;
        if (accepted)  rem_d = load_val;
        else if (busy) rem_d = rem_q - CNT_W'(1);
        else           rem_d = '0;
        done_next = (rem_d == '0);
    end

    // Purpose: hold the remaining interval.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    // R6
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q != '0) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

    // R2
    load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && rem_q == '0) |=> (rem_q == $past(load_val)));
endmodule

// File: rtl/pulse_width_qualifier.sv
// Module: pulse_width_qualifier
// Passes the part of an input pulse that outlasts min_width clock cycles.
// A rising edge of the synchronised input, when the timer is idle, starts
// a programmed interval; the pulse is marked pending and is released to
// the output once the interval has ended, until the input falls.
// Assumes pulse_in is asynchronous; min_width is sampled at edge accept.
module pulse_width_qualifier
    import pwq_pkg::*;
#(
    parameter int unsigned CNT_W       = PWQ_CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = PWQ_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic [CNT_W-1:0] min_width,
    output logic             pulse_out
);
    logic lead_lvl;
    logic sync_lvl;
    logic rise;
    logic tmr_busy;
    logic tmr_accept;
    logic tmr_done_nxt;
    logic pend_q;
    logic pend_d;
    logic out_q;

    pwq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .lead_out (lead_lvl),
        .sync_out (sync_lvl)
    );

    // Purpose: detect a rising edge about to appear on the synced level.
    always_comb rise = lead_lvl && !sync_lvl;

    pwq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (rise),
        .load_val  (min_width),
        .busy      (tmr_busy),
        .accepted  (tmr_accept),
        .done_next (tmr_done_nxt)
    );

    // Purpose: a pulse stays pending from acceptance until it falls.
    always_comb pend_d = tmr_accept || (pend_q && lead_lvl);

    // Purpose: register the pending flag and the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            out_q  <= lead_lvl && pend_d && tmr_done_nxt;
        end
    end

    assign pulse_out = out_q;

    // R3
    quiet_while_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> !tmr_busy);

    // R6
    only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> pend_q);

    // R9
    fall_with_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lead_lvl |=> !pulse_out);
endmodule

// File: tb/tb_pulse_width_qualifier.sv
module tb_pulse_width_qualifier;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic [CNT_W-1:0] min_width = '0;
    logic             pulse_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    pulse_width_qualifier #(.CNT_W(CNT_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (pulse_in),
        .min_width (min_width),
        .pulse_out (pulse_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive up to two pulses (index of first drive, length) with width n;
    // optionally change min_width at index chg_at. Measures first high
    // sample index and the number of high samples.
    task automatic run(input int n, input int s1, input int l1, input int s2, input int l2,
                       input int chg_at, input int chg_val, input int total,
                       output int first, output int width);
        first = -1;
        width = 0;
        min_width = CNT_W'(n);
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (pulse_out) begin
                width++;
                if (first < 0) first = i;
            end
            if (i == chg_at) min_width = CNT_W'(chg_val);
            pulse_in = ((i >= s1) && (i < s1 + l1)) || ((i >= s2) && (i < s2 + l2));
        end
        pulse_in = 1'b0;
    endtask

    task automatic t_reset();
        int f, w;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out in reset", int'(pulse_out), 0);
        rst_n = 1'b1;
        run(3, 0, 0, 0, 0, -1, 0, 10, f, w);
        check("R1", "idle high count", w, 0);
    endtask

    task automatic t_long(input int n, input int l);
        int f, w;
        run(n, 0, l, 0, 0, -1, 0, l + n + 10, f, w);
        check("R4", "first high index", f, n + 2);
        check("R4", "output width", w, l - n);
        // R9: last high sample is index l+1, so f+w-1 == l+1
        check("R9", "fall index", f + w - 1, l + 1);
    endtask

    task automatic t_short(input int n, input int l);
        int f, w;
        run(n, 0, l, 0, 0, -1, 0, l + n + 10, f, w);
        check("R5", "suppressed width", w, 0);
    endtask

    task automatic t_zero(input int l);
        int f, w;
        run(0, 0, l, 0, 0, -1, 0, l + 10, f, w);
        check("R8", "pass first index", f, 2);
        check("R8", "pass width", w, l);
    endtask

    task automatic t_retrig();
        int f, w;
        // second pulse starts while the timer (N=10) still runs
        run(10, 0, 3, 5, 14, -1, 0, 40, f, w);
        check("R6", "retrigger ignored width", w, 0);
        run(4, 0, 2, 3, 9, -1, 0, 25, f, w);
        check("R6", "overlap ignored width", w, 0);
    endtask

    task automatic t_rearm();
        int f, w;
        run(4, 0, 2, 8, 8, -1, 0, 30, f, w);
        check("R7", "rearm first index", f, 8 + 4 + 2);
        check("R7", "rearm width", w, 4);
    endtask

    task automatic t_width_change();
        int f, w;
        run(6, 0, 10, 0, 0, 2, 1, 25, f, w);
        check("R2", "latched width first", f, 8);
        check("R2", "latched width count", w, 4);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_long(3, 8);
        t_long(5, 6);
        t_long(1, 20);
        t_short(5, 5);
        t_short(7, 2);
        t_zero(1);
        t_zero(6);
        t_retrig();
        t_rearm();
        t_width_change();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule